// File: doc/BRIEF.md
# Branch-on-bit condition unit

This unit resolves a conditional branch whose condition is a single bit of a 64-bit register operand. The instruction supplies a 6-bit bit index, a polarity flag and a signed 16-bit word displacement. The unit computes two things: whether the branch is taken, and the target address relative to the current program counter. Every branch it accepts makes the next instruction a 32-bit delay slot, and the unit flags this.

A branch that sits in a delay or forbidden slot is not evaluated. In that case the unit raises a reserved-instruction trap instead. The caller presents one request with a single-cycle valid strobe. The result appears on registered outputs one clock later and stays there until the next strobe.

Top module: `obb_cond_unit`

## Requirements
- R1: The tested bit is `src_val[bit_idx]`, with `bit_idx` ranging over 0..63.
- R2: With `want_set` = 1 the branch is taken when the tested bit is 1. With `want_set` = 0 it is taken when the tested bit is 0.
- R3: `br_target` equals `cur_pc + 4 + 4*sext(disp)`, computed modulo 2^64. `disp` is a two's-complement 16-bit word count, so 0x8000 gives a displacement of -131072 bytes.
- R4: A request with `in_slot` = 0 produces `slot_next` = 1 and `trap_ri` = 0.
- R5: A request with `in_slot` = 1 produces `trap_ri` = 1, `br_taken` = 0, `slot_next` = 0 and `br_target` = 0, whatever the other inputs are.
- R6: `res_valid` is 1 in exactly the cycle after a cycle with `req_valid` = 1, and 0 otherwise. The result outputs take their new values at that same edge.
- R7: While `req_valid` = 0, `br_taken`, `br_target`, `slot_next` and `trap_ri` hold their last values.
- R8: While `rst_n` = 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is expected to be synchronous to `clk` |
| req_valid | input | 1 | One-cycle strobe that presents a branch request |
| src_val | input | 64 | Register operand under test |
| bit_idx | input | 6 | Index of the tested bit |
| want_set | input | 1 | Polarity: 1 = taken if bit set, 0 = taken if bit clear |
| disp | input | 16 | Signed word displacement |
| cur_pc | input | 64 | Address of the branch instruction |
| in_slot | input | 1 | The branch itself occupies a delay or forbidden slot |
| res_valid | output | 1 | Result strobe, one cycle after `req_valid` |
| br_taken | output | 1 | Branch condition met |
| br_target | output | 64 | Branch destination address |
| slot_next | output | 1 | The next instruction is a 32-bit delay slot |
| trap_ri | output | 1 | Reserved-instruction exception |

## Verification
The only state is a single bank of result registers, so a fault in how they are loaded shows up on the very next `res_valid` cycle. Such a fault appears as a wrong taken flag, a wrong target, or a trap that leaves `br_taken` or `slot_next` set. A clock-enable fault shows up differently. It appears as outputs that change during idle cycles. The bench catches it by re-reading the outputs one cycle after each result.

// File: rtl/obb_pkg.sv
package obb_pkg;
  parameter int unsigned XLEN_DEF = 64;
  parameter int unsigned OFFW_DEF = 16;
  parameter int unsigned INSN_BYTES_DEF = 4;

  typedef enum logic {
    POL_CLEAR = 1'b0,
    POL_SET   = 1'b1
  } pol_e;
endpackage

// File: rtl/obb_bit_pick.sv
module obb_bit_pick #(
  parameter int unsigned W  = 64,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  word,
  input  logic [IW-1:0] idx,
  input  obb_pkg::pol_e pol,
  output logic          hit
);
  logic picked;

  always_comb begin
    picked = word[idx];
    hit    = (pol == obb_pkg::POL_SET) ? picked : ~picked;
  end
endmodule

// File: rtl/obb_tgt_calc.sv
module obb_tgt_calc #(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned OFFW       = 16,
  parameter int unsigned INSN_BYTES = 4,
  localparam int unsigned SH        = $clog2(INSN_BYTES)
) (
  input  logic [XLEN-1:0] pc,
  input  logic [OFFW-1:0] disp,
  output logic [XLEN-1:0] tgt
);
  logic [XLEN-1:0] ext;
  logic [XLEN-1:0] scaled;

  generate
    if (XLEN > OFFW) begin : g_sext
      assign ext = {{(XLEN-OFFW){disp[OFFW-1]}}, disp};
    end else begin : g_trunc
      assign ext = disp[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    scaled = ext << SH;
    tgt    = pc + XLEN'(INSN_BYTES) + scaled;
  end
endmodule

// File: rtl/obb_cond_unit.sv
module obb_cond_unit #(
  parameter int unsigned XLEN       = obb_pkg::XLEN_DEF,
  parameter int unsigned OFFW       = obb_pkg::OFFW_DEF,
  parameter int unsigned INSN_BYTES = obb_pkg::INSN_BYTES_DEF,
  localparam int unsigned IW        = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [XLEN-1:0] src_val,
  input  logic [IW-1:0]   bit_idx,
  input  logic            want_set,
  input  logic [OFFW-1:0] disp,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            in_slot,
  output logic            res_valid,
  output logic            br_taken,
  output logic [XLEN-1:0] br_target,
  output logic            slot_next,
  output logic            trap_ri
);
  logic            cond_hit;
  logic [XLEN-1:0] calc_tgt;
  logic            nxt_taken, nxt_slot, nxt_trap;
  logic [XLEN-1:0] nxt_tgt;
  logic            vld_q, taken_q, slot_q, trap_q;
  logic [XLEN-1:0] tgt_q;

  obb_bit_pick #(.W(XLEN)) u_pick (
    .word (src_val),
    .idx  (bit_idx),
    .pol  (obb_pkg::pol_e'(want_set)),
    .hit  (cond_hit)
  );

  obb_tgt_calc #(.XLEN(XLEN), .OFFW(OFFW), .INSN_BYTES(INSN_BYTES)) u_tgt (
    .pc   (cur_pc),
    .disp (disp),
    .tgt  (calc_tgt)
  );

  // next-state
  always_comb begin
    if (in_slot) begin
      nxt_taken = 1'b0;
      nxt_slot  = 1'b0;
      nxt_trap  = 1'b1;
      nxt_tgt   = '0;
    end else begin
      nxt_taken = cond_hit;
      nxt_slot  = 1'b1;
      nxt_trap  = 1'b0;
      nxt_tgt   = calc_tgt;
    end
  end

  // registers, result bank enabled by req_valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      taken_q <= 1'b0;
      slot_q  <= 1'b0;
      trap_q  <= 1'b0;
      tgt_q   <= '0;
    end else begin
      vld_q <= req_valid;
      if (req_valid) begin
        taken_q <= nxt_taken;
        slot_q  <= nxt_slot;
        trap_q  <= nxt_trap;
        tgt_q   <= nxt_tgt;
      end
    end
  end

  assign res_valid = vld_q;
  assign br_taken  = taken_q;
  assign slot_next = slot_q;
  assign trap_ri   = trap_q;
  assign br_target = tgt_q;

  AST_TRAP_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ri |-> (!br_taken && !slot_next && br_target == '0)); // R5
  AST_TRAP_FOLLOWS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_slot) |=> trap_ri); // R5
  AST_SLOT_ON_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !in_slot) |=> (slot_next && !trap_ri)); // R4
  AST_RESULT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid); // R6
  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(br_taken) && $stable(br_target) && $stable(slot_next) && $stable(trap_ri))); // R7
endmodule

// File: tb/sim_obb_cond_unit.sv
`timescale 1ns/1ps
module sim_obb_cond_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] src_val;
  logic [5:0]  bit_idx;
  logic        want_set;
  logic [15:0] disp;
  logic [63:0] cur_pc;
  logic        in_slot;
  logic        res_valid, br_taken, slot_next, trap_ri;
  logic [63:0] br_target;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  obb_cond_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .src_val(src_val),
    .bit_idx(bit_idx), .want_set(want_set), .disp(disp), .cur_pc(cur_pc),
    .in_slot(in_slot), .res_valid(res_valid), .br_taken(br_taken),
    .br_target(br_target), .slot_next(slot_next), .trap_ri(trap_ri)
  );

  function automatic logic exp_taken(logic [63:0] v, int idx, logic pol, logic slot);
    if (slot) return 1'b0;
    return ((v >> idx) & 64'd1) == (pol ? 64'd1 : 64'd0);
  endfunction

  function automatic logic [63:0] exp_tgt(logic [63:0] pc, logic [15:0] d, logic slot);
    longint sd;
    if (slot) return 64'd0;
    sd = longint'($signed(d));
    return pc + 64'd4 + 64'(sd * 4);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [63:0] v, int idx, logic pol, logic [15:0] d,
                       logic [63:0] pc, logic slot);
    logic e_tk; logic [63:0] e_tg;
    @(negedge clk);
    req_valid = 1'b1; src_val = v; bit_idx = 6'(idx); want_set = pol;
    disp = d; cur_pc = pc; in_slot = slot;
    @(negedge clk);
    req_valid = 1'b0; src_val = ~v; bit_idx = ~bit_idx; want_set = ~pol;
    disp = ~d; cur_pc = ~pc; in_slot = ~slot;
    e_tk = exp_taken(v, idx, pol, slot);
    e_tg = exp_tgt(pc, d, slot);
    chk("R6 res_valid", 64'(res_valid), 64'd1);
    chk(slot ? "R5 taken" : "R1/R2 taken", 64'(br_taken), 64'(e_tk));
    chk(slot ? "R5 target" : "R3 target", br_target, e_tg);
    chk(slot ? "R5 slot" : "R4 slot", 64'(slot_next), slot ? 64'd0 : 64'd1);
    chk(slot ? "R5 trap" : "R4 trap", 64'(trap_ri), 64'(slot));
    @(negedge clk);
    chk("R6 strobe drop", 64'(res_valid), 64'd0);
    chk("R7 hold taken", 64'(br_taken), 64'(e_tk));
    chk("R7 hold target", br_target, e_tg);
    chk("R7 hold trap", 64'(trap_ri), 64'(slot));
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid = 1'b0; src_val = '0; bit_idx = '0; want_set = 1'b0;
    disp = '0; cur_pc = '0; in_slot = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset valid", 64'(res_valid), 64'd0);
    chk("R8 reset taken", 64'(br_taken), 64'd0);
    chk("R8 reset target", br_target, 64'd0);
    chk("R8 reset slot", 64'(slot_next), 64'd0);
    chk("R8 reset trap", 64'(trap_ri), 64'd0);
    rst_n = 1'b1;

    // R1 R2 directed positions and polarities
    apply(64'h0000_0000_0000_0001, 0, 1'b1, 16'd3, 64'h1000, 1'b0);
    apply(64'h0000_0000_0000_0001, 0, 1'b0, 16'd3, 64'h1000, 1'b0);
    apply(64'hFFFF_FFFF_7FFF_FFFF, 31, 1'b0, 16'd1, 64'h2000, 1'b0);
    apply(64'hFFFF_FFFF_7FFF_FFFF, 31, 1'b1, 16'd1, 64'h2000, 1'b0);
    apply(64'h8000_0000_0000_0000, 63, 1'b1, 16'd0, 64'h3000, 1'b0);
    apply(64'h7FFF_FFFF_FFFF_FFFF, 63, 1'b0, 16'd0, 64'h3000, 1'b0);
    apply(64'h7FFF_FFFF_FFFF_FFFF, 63, 1'b1, 16'd0, 64'h3000, 1'b0);
    // R3 extreme displacements and wraparound
    apply(64'h1, 0, 1'b1, 16'h7FFF, 64'h0000_0000_0040_0000, 1'b0);
    apply(64'h1, 0, 1'b1, 16'h8000, 64'h0000_0000_0040_0000, 1'b0);
    apply(64'h1, 0, 1'b1, 16'hFFFF, 64'h0, 1'b0);
    apply(64'h1, 0, 1'b1, 16'h0001, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0);
    // R5 trap with a condition that would be taken
    apply(64'hFFFF_FFFF_FFFF_FFFF, 5, 1'b1, 16'h0100, 64'h5000, 1'b1);
    apply(64'h0, 40, 1'b0, 16'h8000, 64'h6000, 1'b1);
    apply(64'h1, 0, 1'b1, 16'd2, 64'h7000, 1'b0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      apply({$urandom, $urandom}, int'($urandom_range(63, 0)), 1'($urandom),
            16'($urandom), {$urandom, $urandom & 32'hFFFF_FFFC},
            ($urandom_range(7, 0) == 0));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule